// File: doc/BRIEF.md
# Delayed-Branch Program Counter with Predicate Qualification

This block produces the instruction fetch address for a deep in-order pipeline in which branches are resolved late. Hardware never flushes the fetches that follow a branch. After a taken branch is resolved, a fixed number of further sequential fetches still go out, and only then does the fetch address jump to the target. The compiler fills those slots with useful work or with nops. The block never stalls by itself, because hazards are scheduled away in software.

Branch direction comes from a small predicate register file. Compare-and-set results from the first execute stage write that file. The same file qualifies every issued instruction. The issue stage presents the instruction's predicate index and receives a "predicate true" bit, which later stages use to nullify side effects. Entry zero always reads true, so unpredicated code uses index 0.

A stall input from the memory side freezes the fetch address, the delay-slot count and any redirect still waiting to happen.

Top module: `dslot_pc_unit`

## Requirements
- R1: While `rst` is high, and for the first cycle after it falls, `fetch_valid_o` is 0 and `fetch_addr_o` equals RESET_VEC. In that cycle, branch and predicate-write inputs are ignored. The first valid fetch address is RESET_VEC.
- R2: In every cycle with `fetch_valid_o` high and `stall_i` low (an advancing cycle) that has no redirect, the next fetch address is the current one plus INSTR_BYTES (4). It wraps modulo 2^PC_W.
- R3: A branch is taken when `br_valid_i` is high in an advancing cycle and the predicate selected by `br_pred_sel_i` reads true. The fetch address shown in that cycle and in the next DELAY_SLOTS-1 advancing cycles follows R2, giving DELAY_SLOTS (4) delay slots. The advancing cycle after those shows the target.
- R4: A branch whose predicate reads false falls through and leaves the fetch sequence unchanged.
- R5: There are NUM_PRED (8) predicates, indexed by 3 bits. When `pw_en_i` is high in an advancing cycle, `pw_val_i` is written to entry `pw_idx_i`. The new value is seen by branches and by `issue_pred_true_o` from the next cycle on, and is not bypassed in the same cycle. Reset clears entries 1 to 7 to false.
- R6: Predicate entry 0 always reads true, and writes to it are ignored.
- R7: If a taken branch resolves while an earlier redirect is still pending, the earlier target is discarded. The delay-slot count restarts from the new branch, and the new target is used, even if the old redirect was due in that same cycle.
- R8: While `stall_i` is high, the fetch address, the delay-slot count and any pending target hold their values. Branch and predicate-write inputs are ignored. The pending redirect completes normally once the stall ends.
- R9: The low log2(INSTR_BYTES) bits of a branch target are forced to zero, so the fetch address is always aligned.
- R10: `issue_pred_true_o` is a combinational read of the predicate entry selected by `issue_pred_sel_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall_i | input | 1 | Memory-side stall, freezes the unit |
| br_valid_i | input | 1 | A branch is resolved in the first execute stage this cycle |
| br_pred_sel_i | input | PRED_IDX_W (3) | Predicate index qualifying the branch |
| br_target_i | input | PC_W (32) | Branch target byte address |
| pw_en_i | input | 1 | Compare-and-set result write enable |
| pw_idx_i | input | PRED_IDX_W (3) | Predicate entry to write |
| pw_val_i | input | 1 | Compare result to store |
| issue_pred_sel_i | input | PRED_IDX_W (3) | Predicate index of the instruction being issued |
| issue_pred_true_o | output | 1 | Selected predicate value; 0 means nullify |
| fetch_addr_o | output | PC_W (32) | Fetch address for this cycle |
| fetch_valid_o | output | 1 | Fetch address is valid |

## Verification
The bench keeps the default 32-bit address, four delay slots and eight predicates. It sets RESET_VEC just below the top of the address space, so sequential fetch wraps through zero within the first few valid fetches. With four delay slots, a second branch can land in the middle of a drain, including the cycle in which the first redirect falls due. Stalls can also be placed at each remaining-slot count. Random phases mix stalls, predicate writes and misaligned targets, and the behavioural model checks them on every cycle.

// File: rtl/dslot_pc_pkg.sv
package dslot_pc_pkg;

   // Redirect tracker state: idle, or counting delay slots down to a redirect.
   typedef enum logic {
      TRK_IDLE  = 1'b0,
      TRK_DRAIN = 1'b1
   } trk_state_e;

   // Elaboration helper: power-of-two test for size parameters.
   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/dslot_pred_file.sv
module dslot_pred_file
   import dslot_pc_pkg::*;
#(
   parameter int NUM_PRED = 8,
   parameter int IDX_W    = $clog2(NUM_PRED)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  logic             wr_val_i,
   input  logic [IDX_W-1:0] rd_a_idx_i,
   output logic             rd_a_o,
   input  logic [IDX_W-1:0] rd_b_idx_i,
   output logic             rd_b_o
);

   if (!is_pow2(NUM_PRED) || NUM_PRED < 2) begin : g_bad_num
      $error("dslot_pred_file: NUM_PRED must be a power of two, at least 2");
   end
   if (IDX_W != $clog2(NUM_PRED)) begin : g_bad_idx
      $error("dslot_pred_file: IDX_W must equal clog2(NUM_PRED)");
   end

   logic [NUM_PRED-1:0] pred_vec;

   for (genvar i = 0; i < NUM_PRED; i++) begin : g_entry
      if (i == 0) begin : g_const
         // entry zero is the always-true predicate for unpredicated code
         assign pred_vec[i] = 1'b1;
      end else begin : g_reg
         logic entry_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               entry_q <= 1'b0;
            end else if (wr_en_i && (wr_idx_i == IDX_W'(i))) begin
               entry_q <= wr_val_i;
            end
         end
         assign pred_vec[i] = entry_q;
      end
   end

   assign rd_a_o = pred_vec[rd_a_idx_i];
   assign rd_b_o = pred_vec[rd_b_idx_i];

   // R6: index zero reads true on both ports whatever was written
   a_r6_zero_reads_true: assert property (@(posedge clk) disable iff (rst)
      ((rd_a_idx_i == '0) |-> rd_a_o) and ((rd_b_idx_i == '0) |-> rd_b_o));

   // R5: a write to a writable entry is visible in the following cycle
   a_r5_write_lands: assert property (@(posedge clk) disable iff (rst)
      (wr_en_i && (wr_idx_i != '0)) |=> (pred_vec[$past(wr_idx_i)] == $past(wr_val_i)));

endmodule

// File: rtl/dslot_redirect_tracker.sv
module dslot_redirect_tracker
   import dslot_pc_pkg::*;
#(
   parameter int PC_W        = 32,
   parameter int DELAY_SLOTS = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            adv_i,
   input  logic            take_i,
   input  logic [PC_W-1:0] target_i,
   output logic            redirect_o,
   output logic [PC_W-1:0] redirect_addr_o
);

   if (DELAY_SLOTS < 1) begin : g_bad_slots
      $error("dslot_redirect_tracker: DELAY_SLOTS must be at least 1");
   end

   localparam int             CNT_W  = $clog2(DELAY_SLOTS + 1);
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(DELAY_SLOTS - 1);
   localparam logic [CNT_W-1:0] LAST   = CNT_W'(1);
   localparam bit             IMMED  = (DELAY_SLOTS == 1);

   trk_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [PC_W-1:0]  tgt_q;
   logic             due;

   assign due = (state_q == TRK_DRAIN) && (cnt_q == LAST);

   always_comb begin
      redirect_o      = 1'b0;
      redirect_addr_o = tgt_q;
      if (adv_i && take_i) begin
         // a newly resolved branch overrides anything pending
         redirect_o      = IMMED;
         redirect_addr_o = target_i;
      end else if (adv_i && due) begin
         redirect_o = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= TRK_IDLE;
         cnt_q   <= '0;
         tgt_q   <= '0;
      end else if (adv_i) begin
         if (take_i) begin
            tgt_q <= target_i;
            if (IMMED) begin
               state_q <= TRK_IDLE;
               cnt_q   <= '0;
            end else begin
               state_q <= TRK_DRAIN;
               cnt_q   <= RELOAD;
            end
         end else if (state_q == TRK_DRAIN) begin
            if (due) begin
               state_q <= TRK_IDLE;
               cnt_q   <= '0;
            end else begin
               cnt_q <= cnt_q - LAST;
            end
         end
      end
   end

   // R3: while draining, the remaining count stays within 1..DELAY_SLOTS-1
   a_r3_count_range: assert property (@(posedge clk) disable iff (rst)
      (state_q == TRK_DRAIN) |-> ((cnt_q != '0) && (cnt_q <= RELOAD)));

   // R3: no redirect ever happens on a frozen cycle
   a_r3_redirect_needs_adv: assert property (@(posedge clk) disable iff (rst)
      redirect_o |-> adv_i);

   // R8: a frozen cycle keeps count, state and pending target
   a_r8_frozen_hold: assert property (@(posedge clk) disable iff (rst)
      !adv_i |=> ($stable(cnt_q) && $stable(tgt_q) && $stable(state_q)));

endmodule

// File: rtl/dslot_pc_unit.sv
module dslot_pc_unit
   import dslot_pc_pkg::*;
#(
   parameter int              PC_W        = 32,
   parameter int              INSTR_BYTES = 4,
   parameter int              DELAY_SLOTS = 4,
   parameter int              NUM_PRED    = 8,
   parameter logic [PC_W-1:0] RESET_VEC   = PC_W'(32'h0000_0100),
   parameter int              PRED_IDX_W  = $clog2(NUM_PRED)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  stall_i,
   input  logic                  br_valid_i,
   input  logic [PRED_IDX_W-1:0] br_pred_sel_i,
   input  logic [PC_W-1:0]       br_target_i,
   input  logic                  pw_en_i,
   input  logic [PRED_IDX_W-1:0] pw_idx_i,
   input  logic                  pw_val_i,
   input  logic [PRED_IDX_W-1:0] issue_pred_sel_i,
   output logic                  issue_pred_true_o,
   output logic [PC_W-1:0]       fetch_addr_o,
   output logic                  fetch_valid_o
);

   localparam logic [PC_W-1:0] STEP     = PC_W'(INSTR_BYTES);
   localparam logic [PC_W-1:0] LOW_MASK = PC_W'(INSTR_BYTES - 1);

   if (!is_pow2(INSTR_BYTES)) begin : g_bad_bytes
      $error("dslot_pc_unit: INSTR_BYTES must be a power of two");
   end
   if ((RESET_VEC & LOW_MASK) != '0) begin : g_bad_vec
      $error("dslot_pc_unit: RESET_VEC must be instruction aligned");
   end
   if (PC_W < 2 || PC_W > 64) begin : g_bad_pcw
      $error("dslot_pc_unit: PC_W out of range");
   end

   logic [PC_W-1:0] pc_q;
   logic            valid_q;
   logic            adv;
   logic            br_pred_ok;
   logic            take;
   logic            redirect;
   logic [PC_W-1:0] redirect_addr;
   logic [PC_W-1:0] tgt_aligned;

   assign adv         = valid_q && !stall_i;
   assign take        = adv && br_valid_i && br_pred_ok;
   assign tgt_aligned = br_target_i & ~LOW_MASK;

   dslot_pred_file #(
      .NUM_PRED (NUM_PRED),
      .IDX_W    (PRED_IDX_W)
   ) u_preds (
      .clk        (clk),
      .rst        (rst),
      .wr_en_i    (adv && pw_en_i),
      .wr_idx_i   (pw_idx_i),
      .wr_val_i   (pw_val_i),
      .rd_a_idx_i (issue_pred_sel_i),
      .rd_a_o     (issue_pred_true_o),
      .rd_b_idx_i (br_pred_sel_i),
      .rd_b_o     (br_pred_ok)
   );

   dslot_redirect_tracker #(
      .PC_W        (PC_W),
      .DELAY_SLOTS (DELAY_SLOTS)
   ) u_track (
      .clk             (clk),
      .rst             (rst),
      .adv_i           (adv),
      .take_i          (take),
      .target_i        (tgt_aligned),
      .redirect_o      (redirect),
      .redirect_addr_o (redirect_addr)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q    <= RESET_VEC;
         valid_q <= 1'b0;
      end else begin
         valid_q <= 1'b1;
         if (adv) begin
            pc_q <= redirect ? redirect_addr : (pc_q + STEP);
         end
      end
   end

   assign fetch_addr_o  = pc_q;
   assign fetch_valid_o = valid_q;

   // R2: an advancing cycle without redirect steps by one instruction
   a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
      (adv && !redirect) |=> (fetch_addr_o == $past(fetch_addr_o) + STEP));

   // R8: nothing moves the fetch address on a frozen cycle
   a_r8_addr_frozen: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(fetch_addr_o));

   // R1: an invalid fetch cycle always presents the reset vector
   a_r1_idle_vector: assert property (@(posedge clk) disable iff (rst)
      !fetch_valid_o |-> (fetch_addr_o == RESET_VEC));

   // R9: the fetch address never carries byte-offset bits
   a_r9_aligned: assert property (@(posedge clk) disable iff (rst)
      (fetch_addr_o & LOW_MASK) == '0);

endmodule

// File: tb/dslot_pc_unit_tb.sv
`timescale 1ns/1ps
module dslot_pc_unit_tb_top;

   localparam int          D  = 4;
   localparam logic [31:0] RV = 32'hFFFF_FFF0;

   logic        clk = 1'b0;
   logic        rst;
   logic        stall_i, br_valid_i, pw_en_i, pw_val_i;
   logic [2:0]  br_pred_sel_i, pw_idx_i, issue_pred_sel_i;
   logic [31:0] br_target_i;
   logic        issue_pred_true_o, fetch_valid_o;
   logic [31:0] fetch_addr_o;

   always #2 clk = ~clk;

   dslot_pc_unit #(
      .PC_W(32), .INSTR_BYTES(4), .DELAY_SLOTS(D), .NUM_PRED(8), .RESET_VEC(RV)
   ) dut_i (
      .clk(clk), .rst(rst), .stall_i(stall_i), .br_valid_i(br_valid_i),
      .br_pred_sel_i(br_pred_sel_i), .br_target_i(br_target_i),
      .pw_en_i(pw_en_i), .pw_idx_i(pw_idx_i), .pw_val_i(pw_val_i),
      .issue_pred_sel_i(issue_pred_sel_i), .issue_pred_true_o(issue_pred_true_o),
      .fetch_addr_o(fetch_addr_o), .fetch_valid_o(fetch_valid_o)
   );

   int tests = 0;
   int fails = 0;

   // behavioural reference state
   logic [31:0] m_pc;
   logic        m_fv;
   bit          m_pred[8];
   logic [31:0] m_pending[$];   // at most one pending target, newest replaces
   int          m_left;

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic cyc(input string req);
      logic [31:0] n_pc;
      logic        n_fv;
      bit          n_pred[8];
      bit          adv, tk;
      #1;
      chk(req, "fetch_valid", {31'b0, fetch_valid_o}, {31'b0, m_fv});
      chk(req, "fetch_addr", fetch_addr_o, m_pc);
      chk(req, "issue_pred_true", {31'b0, issue_pred_true_o},
          {31'b0, m_pred[issue_pred_sel_i]});
      n_pc = m_pc;
      n_pred = m_pred;
      if (rst) begin
         n_fv = 1'b0;
         n_pc = RV;
         for (int i = 1; i < 8; i++) n_pred[i] = 1'b0;
      end else begin
         n_fv = 1'b1;
         adv = m_fv && !stall_i;
         if (adv) begin
            tk = br_valid_i && m_pred[br_pred_sel_i];
            if (tk) begin
               m_pending.delete();
               if (D == 1) n_pc = br_target_i & ~32'd3;
               else begin
                  n_pc = m_pc + 32'd4;
                  m_pending.push_back(br_target_i & ~32'd3);
                  m_left = D - 1;
               end
            end else if (m_pending.size() != 0) begin
               if (m_left == 1) n_pc = m_pending.pop_front();
               else begin
                  n_pc = m_pc + 32'd4;
                  m_left--;
               end
            end else n_pc = m_pc + 32'd4;
            if (pw_en_i && pw_idx_i != 3'd0) n_pred[pw_idx_i] = pw_val_i;
         end
      end
      @(posedge clk);
      if (rst) m_pending.delete();
      m_pc = n_pc;
      m_fv = n_fv;
      m_pred = n_pred;
      @(negedge clk);
   endtask

   task automatic quiet();
      stall_i = 0; br_valid_i = 0; pw_en_i = 0; pw_val_i = 0;
      br_pred_sel_i = 0; pw_idx_i = 0; br_target_i = 0;
   endtask

   task automatic idle(input int n, input string req);
      for (int i = 0; i < n; i++) cyc(req);
   endtask

   task automatic branch(input logic [2:0] sel, input logic [31:0] tgt, input string req);
      br_valid_i = 1; br_pred_sel_i = sel; br_target_i = tgt;
      cyc(req);
      br_valid_i = 0;
   endtask

   task automatic pwrite(input logic [2:0] idx, input bit val, input string req);
      pw_en_i = 1; pw_idx_i = idx; pw_val_i = val;
      cyc(req);
      pw_en_i = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      m_pc = RV; m_fv = 0; m_left = 0;
      for (int i = 0; i < 8; i++) m_pred[i] = (i == 0);
      rst = 1; issue_pred_sel_i = 0;
      quiet();
      @(negedge clk);
      @(negedge clk);
      idle(2, "R1");
      rst = 0;
      // R1: first cycle after release is invalid; branch here must be ignored
      branch(3'd0, 32'h0000_7000, "R1");
      // R2: sequential stepping across the top of the address space
      idle(6, "R2");
      // R3: taken branch through always-true predicate
      branch(3'd0, 32'h0000_0200, "R3");
      idle(6, "R3");
      // R5 / R10: write a predicate and read every index
      pwrite(3'd3, 1'b1, "R5");
      for (int s = 0; s < 8; s++) begin
         issue_pred_sel_i = 3'(s);
         cyc("R10");
      end
      issue_pred_sel_i = 0;
      // R4: false predicate falls through
      branch(3'd5, 32'h0000_0900, "R4");
      idle(6, "R4");
      // R9: misaligned target, predicate true
      branch(3'd3, 32'h0000_0403, "R9");
      idle(6, "R9");
      // R6: writes to entry zero ignored
      pwrite(3'd0, 1'b0, "R6");
      issue_pred_sel_i = 0;
      cyc("R6");
      branch(3'd0, 32'h0000_0300, "R6");
      idle(6, "R6");
      // R7: second branch mid-drain, and one exactly on the due cycle
      branch(3'd0, 32'h0000_1000, "R7");
      idle(1, "R7");
      branch(3'd3, 32'h0000_2000, "R7");
      idle(2, "R7");
      branch(3'd0, 32'h0000_2800, "R7");
      idle(6, "R7");
      // R8: stall mid-drain with ignored branch and predicate write
      branch(3'd0, 32'h0000_3000, "R8");
      idle(1, "R8");
      stall_i = 1; br_valid_i = 1; br_pred_sel_i = 0; br_target_i = 32'h0000_5000;
      pw_en_i = 1; pw_idx_i = 3'd2; pw_val_i = 1;
      idle(3, "R8");
      quiet();
      idle(6, "R8");
      issue_pred_sel_i = 3'd2;
      cyc("R8");
      issue_pred_sel_i = 0;
      // R3: random traffic against the model
      for (int k = 0; k < 400; k++) begin
         stall_i          = ($urandom_range(0, 7) == 0);
         br_valid_i       = ($urandom_range(0, 5) == 0);
         br_pred_sel_i    = 3'($urandom_range(0, 7));
         br_target_i      = $urandom();
         pw_en_i          = ($urandom_range(0, 3) == 0);
         pw_idx_i         = 3'($urandom_range(0, 7));
         pw_val_i         = 1'($urandom_range(0, 1));
         issue_pred_sel_i = 3'($urandom_range(0, 7));
         cyc("R3");
      end
      quiet();
      for (int i = 1; i < 8; i++) pwrite(3'(i), 1'b1, "R5");
      // R5: reset clears writable predicates, R1 returns to the vector
      rst = 1;
      for (int s = 0; s < 8; s++) begin
         issue_pred_sel_i = 3'(s);
         cyc("R5");
      end
      rst = 0;
      issue_pred_sel_i = 3'd7;
      idle(4, "R1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule